// File: doc/BRIEF.md
# Parallel Character Input Port with Read Handshake

This block accepts 8-bit characters presented in parallel by a keyboard or by a host controller, keeps the most recent one in a single holding register for a processor, and flags its arrival with an active-low interrupt request. The sender places the byte on the data lines and then pulls an active-low strobe. The strobe is brought into the clock domain by a two-flop synchronizer. A one-cycle capture pulse is then formed from its falling edge only, so a long or slow strobe still counts as exactly one character.

The processor takes the byte with a one-cycle read request. That read releases the interrupt request. It also sends the sender a fixed-width active-low acknowledge pulse, about 1.183 µs long and rounded to whole clock cycles from a clock-frequency parameter. A host sender waits for this pulse before it presents its next byte. A keyboard sender may ignore it. If a second character lands before the first is read, the newer byte replaces the older one and an overrun flag is raised. The next read clears that flag.

Top module: `kbd_latch_port`

## Requirements
- R1: After reset, irq_n is 1, ack_n is 1, overrun is 0 and rd_data is 0x00.
- R2: When kb_stb_n goes from 1 to 0, the byte on kb_data is loaded into rd_data and irq_n drops to 0. Both take effect at the third rising clock edge after the strobe goes low, and not earlier.
- R3: A strobe held low creates exactly one capture, however long it stays low. The rising edge of kb_stb_n captures nothing.
- R4: A read (rd = 1 for one cycle) while irq_n is 0 sets irq_n to 1 at that clock edge, unless a capture lands on the same edge (R9).
- R5: A read while irq_n is 0 drives ack_n low from that clock edge for exactly ACK_CYC cycles. ACK_CYC = round(CLK_KHZ × ACK_NS / 10^6), which is 59 at 50 MHz.
- R6: A read while irq_n is 1 does not start an acknowledge pulse and changes neither rd_data nor irq_n.
- R7: A capture while irq_n is 0 and no read is given replaces rd_data and sets overrun to 1. A read of a pending byte clears overrun to 0.
- R8: rd_data changes only on a capture. Reads leave it unchanged.
- R9: If a capture and a read of a pending byte fall on the same edge, the new byte is kept, irq_n stays 0, overrun is 0 and an acknowledge pulse starts.
- R10: A read of a pending byte while ack_n is already low restarts the pulse, so ack_n stays low for ACK_CYC cycles counted from the newer read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kb_data | input | 8 | Parallel character from the sender, positive logic |
| kb_stb_n | input | 1 | Active-low data strobe from the sender, asynchronous |
| rd | input | 1 | One-cycle processor read request |
| rd_data | output | 8 | Holding register contents |
| irq_n | output | 1 | Active-low interrupt request, low while a byte is unread |
| ack_n | output | 1 | Active-low acknowledge pulse to the sender |
| overrun | output | 1 | A byte was overwritten before it was read |

## Verification
The bound checker watches several rules on every cycle. A pending request survives until it is read. A pending read releases the request. An acknowledge only begins after a pending read, and a read of an empty register never starts one. The overrun flag only stands alongside a pending request, and the held byte never moves while the request stays released. The bench's scenarios show the rest: the exact three-edge capture latency, the single capture from a held strobe, the 59-cycle pulse width and its restart, and the collision of a capture with a read. A behavioural reference model is compared against every output on every clock.

// File: rtl/kbd_latch_port.sv
module kbd_latch_port #(
  parameter int CLK_KHZ = 50000,
  parameter int ACK_NS  = 1183,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] kb_data,
  input  logic          kb_stb_n,
  input  logic          rd,
  output logic [DW-1:0] rd_data,
  output logic          irq_n,
  output logic          ack_n,
  output logic          overrun
);
  localparam int ACK_RAW = (CLK_KHZ * ACK_NS + 500_000) / 1_000_000;
  localparam int ACK_CYC = (ACK_RAW < 1) ? 1 : ACK_RAW;
  localparam int CW      = $clog2(ACK_CYC + 1);

  logic [2:0]    stb_sr;
  logic [CW-1:0] ack_cnt;

  wire take    = stb_sr[2] & ~stb_sr[1];
  wire consume = rd & ~irq_n;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_sr <= 3'b111;
    else        stb_sr <= {stb_sr[1:0], kb_stb_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq_n   <= 1'b1;
      overrun <= 1'b0;
    end else begin
      if (take) rd_data <= kb_data;
      irq_n   <= take ? 1'b0 : (consume ? 1'b1 : irq_n);
      overrun <= consume ? 1'b0 : (take & ~irq_n) | overrun;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ack_cnt <= '0;
    else if (consume)    ack_cnt <= CW'(ACK_CYC);
    else if (ack_cnt != 0) ack_cnt <= ack_cnt - 1'b1;
  end

  assign ack_n = (ack_cnt == 0);
endmodule

module kbd_latch_port_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd,
  input logic [DW-1:0] rd_data,
  input logic          irq_n,
  input logic          ack_n,
  input logic          overrun
);
  // R2
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd) |=> !irq_n);
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && rd) |=> (irq_n || !ack_n));
  // R5
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n && !rd) |=> ack_n);
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && ack_n && rd) |=> ack_n);
  // R7
  overrun_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !irq_n);
  // R8
  data_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && $past(irq_n)) |-> $stable(rd_data));
endmodule

bind kbd_latch_port kbd_latch_port_chk #(.DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .rd_data(rd_data),
  .irq_n(irq_n), .ack_n(ack_n), .overrun(overrun)
);

// File: tb/tb_kbd_latch_port.sv
module tb_kbd_latch_port;
  localparam int ACK_CYC = 59;

  logic clk = 0, rst_n = 0, kb_stb_n = 1, rd = 0;
  logic [7:0] kb_data = 8'h00;
  logic [7:0] rd_data;
  logic irq_n, ack_n, overrun;

  int errors = 0, checks = 0;
  bit done = 0;

  kbd_latch_port dut (.clk(clk), .rst_n(rst_n), .kb_data(kb_data), .kb_stb_n(kb_stb_n),
    .rd(rd), .rd_data(rd_data), .irq_n(irq_n), .ack_n(ack_n), .overrun(overrun));

  always #10 clk = ~clk;

  // reference model
  bit   hist[$] = '{1, 1, 1};
  logic [7:0] m_data = 0;
  bit   m_pend = 0, m_ovr = 0;
  int   m_ack = 0;

  always @(posedge clk) begin
    bit fall, eat;
    if (!rst_n) begin
      hist = '{1, 1, 1}; m_data = 0; m_pend = 0; m_ovr = 0; m_ack = 0;
    end else begin
      fall = hist[2] && !hist[1];
      void'(hist.pop_back());
      hist.push_front(kb_stb_n);
      eat = rd && m_pend;
      if (eat) m_ack = ACK_CYC; else if (m_ack > 0) m_ack--;
      if (fall) begin
        m_data = kb_data;
        m_ovr  = eat ? 0 : (m_ovr || m_pend);
        m_pend = 1;
      end else if (eat) begin
        m_ovr = 0; m_pend = 0;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!done) begin
      check("R2 model rd_data", rd_data, m_data);
      check("R4 model irq_n", irq_n, !m_pend);
      check("R5 model ack_n", ack_n, m_ack == 0);
      check("R7 model overrun", overrun, m_ovr);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, int low);
    @(negedge clk); kb_data = b; kb_stb_n = 0;
    cyc(low); kb_stb_n = 1; cyc(4);
  endtask

  task automatic read_count(output int w);
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    w = 0;
    while (!ack_n && w < 200) begin w++; @(posedge clk); #5; end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w;
    cyc(3); rst_n = 1;
    @(posedge clk); #5;
    check("R1 irq_n", irq_n, 1); check("R1 ack_n", ack_n, 1);
    check("R1 overrun", overrun, 0); check("R1 rd_data", rd_data, 0);

    // R2 latency
    @(negedge clk); kb_data = 8'h41; kb_stb_n = 0;
    @(posedge clk); @(posedge clk); #5;
    check("R2 irq_n before third edge", irq_n, 1);
    @(posedge clk); #5;
    check("R2 irq_n at third edge", irq_n, 0);
    check("R2 rd_data", rd_data, 8'h41);
    // R3 held strobe: read, strobe still low, no new capture
    cyc(2); kb_data = 8'h99;
    read_count(w);
    check("R5 ack width", w, ACK_CYC);
    cyc(10);
    check("R3 held strobe no recapture irq_n", irq_n, 1);
    kb_stb_n = 1; cyc(6);
    check("R3 rising edge no capture irq_n", irq_n, 1);
    check("R8 data after read", rd_data, 8'h41);

    // R6 empty read
    read_count(w);
    check("R6 no ack on empty read", w, 0);
    check("R6 rd_data", rd_data, 8'h41);
    check("R6 irq_n", irq_n, 1);

    // R7 overrun
    send(8'h31, 2);
    send(8'h32, 8);
    check("R7 newest byte", rd_data, 8'h32);
    check("R7 overrun set", overrun, 1);
    read_count(w);
    check("R7 overrun cleared", overrun, 0);
    check("R4 irq_n after read", irq_n, 1);

    // R9 capture coinciding with read
    send(8'h55, 2);
    cyc(70);
    @(negedge clk); kb_data = 8'h66; kb_stb_n = 0;
    @(negedge clk);
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    check("R9 new byte", rd_data, 8'h66);
    check("R9 irq_n stays low", irq_n, 0);
    check("R9 overrun", overrun, 0);
    check("R9 ack started", ack_n, 0);
    kb_stb_n = 1;

    // R10 retrigger during ack
    cyc(20);
    read_count(w);
    check("R10 ack restarted width", w, ACK_CYC);
    check("R10 irq_n", irq_n, 1);

    cyc(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule